// File: doc/BRIEF.md
# FM Synth Card Host Port Decoder

This block sits between a host I/O bus and the register file of an FM synthesis card. The host touches a small window of port addresses: even offsets carry a register index, odd offsets carry data, and reads return timer/status bytes. The decoder keeps the latched indices, turns each data write into one write on a single downstream register port (9-bit address, 8-bit data), and builds every status read from the two status inputs of the synthesis chips.

The card runs in one of four modes, chosen by a static input. In single mode it acts as one chip with an 8-bit index. In extended mode it acts as one two-bank chip with a 9-bit index, where port bit 1 selects the bank. Dual mode emulates two independent single chips on one two-bank core. Each data write can be steered to one chip or broadcast to both. Writes that the old chips lack are filtered, and the stereo pan bits are forced so that chip 0 plays left and chip 1 plays right. The fourth mode is extended mode plus an auxiliary control chip. Magic index values switch this chip on and off, and it holds a left and a right volume register that are brought out as 5-bit gains.

A dual-mode broadcast issues two downstream writes on consecutive cycles. The host leaves at least one idle cycle after any data write.

Top module: `fm_port_decoder`

## Requirements
- R1: Under reset the control chip is inactive and both volume registers hold 0xFF, so both gain outputs read 0x1F. No downstream write is issued in the cycle after reset release, except the dual-mode write of R4.
- R2: Single mode: an index write (port bit 0 = 0) latches 8 bits. A data write (port bit 0 = 1) issues one write in the next cycle, to address {0, index} with the host data. A read of port offset 0 (bits 1:0 = 0) returns status 0 ORed with 0x06, and any other offset returns 0xFF.
- R3: Extended mode: an index write latches the 9-bit value {port bit 1, data}, and a data write issues a write to that 9-bit address. A read of offset 0 returns status 0 unchanged, and any other offset returns 0xFF.
- R4: In the cycle after reset release in dual mode, or after the mode input changes to dual, the downstream port writes 0x01 to address 0x105.
- R5: Dual mode keeps one 8-bit index per chip. With port bit 3 = 0, an access goes to chip (port bit 1). With port bit 3 = 1, it goes to both chips. A chip-1 write uses address 0x100 + register. A broadcast issues the chip-0 write in the next cycle and the chip-1 write in the cycle after.
- R6: Dual mode: a write to register 0x05 is dropped for that chip. Data for registers 0xE0 to 0xFF is masked to its low 2 bits.
- R7: Dual mode: data for registers 0xC0 to 0xC8 keeps its low nibble, and its high nibble is forced to 0x5 for chip 0 and 0xA for chip 1.
- R8: Dual mode reads: odd ports return 0xFF. Even ports return the status of chip (port bit 1) ORed with 0x06.
- R9: Control-chip mode: an index write of 0xFF to port 0xA turns the control chip on, and 0xFE turns it off. Neither value changes the synth index. While the control chip is inactive, all accesses behave as in extended mode.
- R10: While the control chip is active, an index write to port 0xA selects a control register. A data write to port 0xB stores the left volume at control index 0x09 or the right volume at 0x0A, and is dropped otherwise. These writes cause no downstream write. The gain outputs are the low 5 bits of the volumes, and they change only after a host write.
- R11: While the control chip is active, a read of port 0xA returns 0x00. A read of port 0xB returns 0x70 for control index 0x00, the left volume for 0x09, the right volume for 0x0A, 0x71 for 0x15, and 0xFF for any other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 single, 1 dual, 2 extended, 3 extended with control chip |
| port_i | input | 4 | Low four bits of the host port address |
| wr_i | input | 1 | Host write strobe, one cycle per access |
| rd_i | input | 1 | Host read strobe; read data is zero when low |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, combinational from port and state |
| stat0_i | input | 8 | Status byte of chip 0 (the only chip outside dual mode) |
| stat1_i | input | 8 | Status byte of chip 1 |
| reg_we_o | output | 1 | Downstream register write strobe |
| reg_addr_o | output | 9 | Downstream register address |
| reg_data_o | output | 8 | Downstream register data |
| vol_l_o | output | 5 | Left gain from the control chip |
| vol_r_o | output | 5 | Right gain from the control chip |

## Verification
The bench aims at the dual-mode filters. It writes register 0x05, writes the 0xE0 range with high bits set, and broadcasts to the pan registers with all data bits set. A design that forgot the drop would pass writes to 0x05 and could clear the two-bank enable. One that patched the pan bits with the wrong chip's value would swap the stereo sides. One that lost the second write of a broadcast would leave chip 1 silent. The control-chip tests use the magic values both while the chip is active and while it is inactive. A decoder that latched 0xFF or 0xFE as a synth index would send the next data write to the wrong register. Reads check the 0x06 OR in single and dual modes and its absence in extended mode.

// File: rtl/fmpd_pkg.sv
package fmpd_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 9;
    localparam int PORT_W = 4;
    localparam int NCHIP  = 2;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_DUAL   = 2'd1,
        MODE_EXT    = 2'd2,
        MODE_CTRL   = 2'd3
    } mode_e;

    localparam logic [PORT_W-1:0] CTRL_IDX_PORT  = 4'hA;
    localparam logic [PORT_W-1:0] CTRL_DATA_PORT = 4'hB;
    localparam logic [DATA_W-1:0] CTRL_ON        = 8'hFF;
    localparam logic [DATA_W-1:0] CTRL_OFF       = 8'hFE;
    localparam logic [ADDR_W-1:0] DUAL_INIT_ADDR = 9'h105;
    localparam logic [DATA_W-1:0] DUAL_INIT_DATA = 8'h01;
    localparam logic [DATA_W-1:0] STAT_PAD       = 8'h06;

    typedef struct packed {
        logic              v;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_t;

    typedef struct packed {
        logic [ADDR_W-1:0]            idx;
        logic [NCHIP-1:0][DATA_W-1:0] didx;
        wr_t                          pend;
        wr_t                          out;
        mode_e                        mode;
    } dec_st_t;

    typedef struct packed {
        logic              active;
        logic [DATA_W-1:0] idx;
        logic [DATA_W-1:0] vl;
        logic [DATA_W-1:0] vr;
    } ctrl_st_t;
endpackage

// File: rtl/fmpd_dual_xform.sv
module fmpd_dual_xform
    import fmpd_pkg::*;
#(
    parameter int CHIP = 0
) (
    input  logic [DATA_W-1:0] reg_i,
    input  logic [DATA_W-1:0] data_i,
    output wr_t               cmd_o
);
    localparam logic [3:0] PAN_BITS = (CHIP != 0) ? 4'hA : 4'h5;
    localparam logic       BANK     = (CHIP != 0);

    always_comb begin
        cmd_o.v    = (reg_i != 8'h05);
        cmd_o.addr = {BANK, reg_i};
        cmd_o.data = data_i;
        if (reg_i >= 8'hE0) begin
            cmd_o.data = {6'b0, data_i[1:0]};
        end else if (reg_i >= 8'hC0 && reg_i <= 8'hC8) begin
            cmd_o.data = {PAN_BITS, data_i[3:0]};
        end
    end
endmodule

// File: rtl/fmpd_ctrl.sv
module fmpd_ctrl
    import fmpd_pkg::*;
#(
    parameter int GAIN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wr_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              claim_wr_o,
    output logic              claim_rd_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              active_o,
    output logic [GAIN_W-1:0] vol_l_o,
    output logic [GAIN_W-1:0] vol_r_o
);
    ctrl_st_t st_d, st_q;
    logic     at_idx, at_dat;

    assign at_idx = (port_i == CTRL_IDX_PORT);
    assign at_dat = (port_i == CTRL_DATA_PORT);

    always_comb begin
        st_d       = st_q;
        claim_wr_o = 1'b0;
        if (en_i && wr_i && at_idx) begin
            if (wdata_i == CTRL_ON) begin
                st_d.active = 1'b1;
                claim_wr_o  = 1'b1;
            end else if (wdata_i == CTRL_OFF) begin
                st_d.active = 1'b0;
                claim_wr_o  = 1'b1;
            end else if (st_q.active) begin
                st_d.idx   = wdata_i;
                claim_wr_o = 1'b1;
            end
        end
        if (en_i && wr_i && at_dat && st_q.active) begin
            claim_wr_o = 1'b1;
            if (st_q.idx == 8'h09) st_d.vl = wdata_i;
            if (st_q.idx == 8'h0A) st_d.vr = wdata_i;
        end
    end

    always_comb begin
        claim_rd_o = en_i && st_q.active && (at_idx || at_dat);
        if (at_idx) begin
            rdata_o = 8'h00;
        end else begin
            case (st_q.idx)
                8'h00:   rdata_o = 8'h70;
                8'h09:   rdata_o = st_q.vl;
                8'h0A:   rdata_o = st_q.vr;
                8'h15:   rdata_o = 8'h71;
                default: rdata_o = 8'hFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.active <= 1'b0;
            st_q.idx    <= '0;
            st_q.vl     <= 8'hFF;
            st_q.vr     <= 8'hFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign vol_l_o  = st_q.vl[GAIN_W-1:0];
    assign vol_r_o  = st_q.vr[GAIN_W-1:0];
endmodule

// File: rtl/fmpd_rdmux.sv
module fmpd_rdmux
    import fmpd_pkg::*;
(
    input  mode_e             mode_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] stat0_i,
    input  logic [DATA_W-1:0] stat1_i,
    input  logic              ctrl_claim_i,
    input  logic [DATA_W-1:0] ctrl_data_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] val;

    always_comb begin
        if (ctrl_claim_i) begin
            val = ctrl_data_i;
        end else begin
            case (mode_i)
                MODE_SINGLE: val = (port_i[1:0] == 2'b00) ? (stat0_i | STAT_PAD) : 8'hFF;
                MODE_DUAL:   val = port_i[0] ? 8'hFF
                                 : ((port_i[1] ? stat1_i : stat0_i) | STAT_PAD);
                default:     val = (port_i[1:0] == 2'b00) ? stat0_i : 8'hFF;
            endcase
        end
        rdata_o = rd_i ? val : '0;
    end
endmodule

// File: rtl/fm_port_decoder.sv
module fm_port_decoder
    import fmpd_pkg::*;
#(
    parameter int GAIN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [3:0]        port_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    input  logic [7:0]        stat0_i,
    input  logic [7:0]        stat1_i,
    output logic              reg_we_o,
    output logic [8:0]        reg_addr_o,
    output logic [7:0]        reg_data_o,
    output logic [GAIN_W-1:0] vol_l_o,
    output logic [GAIN_W-1:0] vol_r_o
);
    mode_e             mode;
    dec_st_t           st_d, st_q;
    wr_t               xcmd [NCHIP];
    wr_t               host_cmd, host_pend;
    logic              sel0, sel1;
    logic              ctrl_claim_wr, ctrl_claim_rd, ctrl_active;
    logic [DATA_W-1:0] ctrl_rdata;

    assign mode = mode_e'(mode_i);

    for (genvar c = 0; c < NCHIP; c++) begin : g_chip
        fmpd_dual_xform #(.CHIP(c)) u_xf (
            .reg_i  (st_q.didx[c]),
            .data_i (wdata_i),
            .cmd_o  (xcmd[c])
        );
    end

    fmpd_ctrl #(.GAIN_W(GAIN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (mode == MODE_CTRL),
        .wr_i       (wr_i),
        .port_i     (port_i),
        .wdata_i    (wdata_i),
        .claim_wr_o (ctrl_claim_wr),
        .claim_rd_o (ctrl_claim_rd),
        .rdata_o    (ctrl_rdata),
        .active_o   (ctrl_active),
        .vol_l_o    (vol_l_o),
        .vol_r_o    (vol_r_o)
    );

    fmpd_rdmux u_rd (
        .mode_i       (mode),
        .port_i       (port_i),
        .rd_i         (rd_i),
        .stat0_i      (stat0_i),
        .stat1_i      (stat1_i),
        .ctrl_claim_i (ctrl_claim_rd),
        .ctrl_data_i  (ctrl_rdata),
        .rdata_o      (rdata_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.out  = '0;
        st_d.mode = mode;
        host_cmd  = '0;
        host_pend = '0;
        sel0      = port_i[3] | ~port_i[1];
        sel1      = port_i[3] | port_i[1];

        if (wr_i && !ctrl_claim_wr) begin
            if (mode == MODE_DUAL) begin
                if (!port_i[0]) begin
                    if (port_i[3]) begin
                        st_d.didx[0] = wdata_i;
                        st_d.didx[1] = wdata_i;
                    end else begin
                        st_d.didx[port_i[1]] = wdata_i;
                    end
                end else if (sel0 && xcmd[0].v) begin
                    host_cmd = xcmd[0];
                    if (sel1 && xcmd[1].v) host_pend = xcmd[1];
                end else if (sel1 && xcmd[1].v) begin
                    host_cmd = xcmd[1];
                end
            end else begin
                if (!port_i[0]) begin
                    st_d.idx = (mode == MODE_SINGLE) ? {1'b0, wdata_i} : {port_i[1], wdata_i};
                end else begin
                    host_cmd.v    = 1'b1;
                    host_cmd.addr = (mode == MODE_SINGLE) ? {1'b0, st_q.idx[7:0]} : st_q.idx;
                    host_cmd.data = wdata_i;
                end
            end
        end

        if (st_q.pend.v) begin
            st_d.out  = st_q.pend;
            st_d.pend = '0;
        end else if (mode == MODE_DUAL && st_q.mode != MODE_DUAL) begin
            st_d.out.v    = 1'b1;
            st_d.out.addr = DUAL_INIT_ADDR;
            st_d.out.data = DUAL_INIT_DATA;
        end else begin
            st_d.out  = host_cmd;
            st_d.pend = host_pend;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx  <= '0;
            st_q.didx <= '0;
            st_q.pend <= '0;
            st_q.out  <= '0;
            st_q.mode <= MODE_SINGLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_we_o   = st_q.out.v;
    assign reg_addr_o = st_q.out.addr;
    assign reg_data_o = st_q.out.data;
endmodule

// File: rtl/fmpd_checker.sv
module fmpd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic [3:0] port_i,
    input logic       wr_i,
    input logic       rd_i,
    input logic [7:0] rdata_o,
    input logic       reg_we_o,
    input logic [8:0] reg_addr_o,
    input logic [7:0] reg_data_o,
    input logic [4:0] vol_l_o,
    input logic [4:0] vol_r_o,
    input logic       ctrl_active
);
    AST_DUAL_REG5_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_o && mode_i == 2'd1 && $past(mode_i) == 2'd1 && $past(mode_i, 2) == 2'd1
         && reg_addr_o[7:0] == 8'h05) |-> (reg_addr_o == 9'h105 && reg_data_o == 8'h01)); // R6

    AST_DUAL_WAVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_o && mode_i == 2'd1 && $past(mode_i) == 2'd1 && $past(mode_i, 2) == 2'd1
         && reg_addr_o[7:0] >= 8'hE0) |-> (reg_data_o[7:2] == 6'd0)); // R6

    AST_DUAL_PAN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_o && mode_i == 2'd1 && $past(mode_i) == 2'd1 && $past(mode_i, 2) == 2'd1
         && reg_addr_o[7:0] >= 8'hC0 && reg_addr_o[7:0] <= 8'hC8)
        |-> (reg_data_o[7:4] == (reg_addr_o[8] ? 4'hA : 4'h5))); // R7

    AST_SINGLE_LOW_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_o && mode_i == 2'd0 && $past(mode_i) == 2'd0 && $past(mode_i, 2) == 2'd0)
        |-> !reg_addr_o[8]); // R2

    AST_DUAL_ODD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && mode_i == 2'd1 && port_i[0]) |-> (rdata_o == 8'hFF)); // R8

    AST_CTRL_IDX_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && mode_i == 2'd3 && ctrl_active && port_i == 4'hA) |-> (rdata_o == 8'h00)); // R11

    AST_VOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ($stable(vol_l_o) && $stable(vol_r_o))); // R10
endmodule

bind fm_port_decoder fmpd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .port_i      (port_i),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .rdata_o     (rdata_o),
    .reg_we_o    (reg_we_o),
    .reg_addr_o  (reg_addr_o),
    .reg_data_o  (reg_data_o),
    .vol_l_o     (vol_l_o),
    .vol_r_o     (vol_r_o),
    .ctrl_active (ctrl_active)
);

// File: tb/tb_fm_port_decoder.sv
module tb_fm_port_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [3:0] port_i = '0;
    logic       wr_i = 1'b0, rd_i = 1'b0;
    logic [7:0] wdata_i = '0, stat0_i = '0, stat1_i = '0;
    logic [7:0] rdata_o, reg_data_o;
    logic       reg_we_o;
    logic [8:0] reg_addr_o;
    logic [4:0] vol_l_o, vol_r_o;

    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    fm_port_decoder dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .port_i(port_i), .wr_i(wr_i),
        .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .stat0_i(stat0_i),
        .stat1_i(stat1_i), .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o),
        .reg_data_o(reg_data_o), .vol_l_o(vol_l_o), .vol_r_o(vol_r_o)
    );

    // reference state
    logic [8:0] m_idx;
    logic [7:0] m_didx [2];
    logic       m_act;
    logic [7:0] m_cidx, m_vl, m_vr;
    logic       ev [2];
    logic [8:0] ea [2];
    logic [7:0] ed [2];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] dual_ref(input logic chip, input logic [7:0] r, input logic [7:0] d);
        logic [7:0] o;
        o = d;
        if (r >= 8'hE0) o = d & 8'h03;
        else if (r >= 8'hC0 && r <= 8'hC8) o = (d & 8'h0F) | (chip ? 8'hA0 : 8'h50);
        return {r != 8'h05, chip, r, o};
    endfunction

    function automatic logic [7:0] rd_ref(input logic [3:0] p, input logic [7:0] s0, input logic [7:0] s1);
        if (mode_i == 2'd3 && m_act && p == 4'hA) return 8'h00;
        if (mode_i == 2'd3 && m_act && p == 4'hB) begin
            case (m_cidx)
                8'h00: return 8'h70;
                8'h09: return m_vl;
                8'h0A: return m_vr;
                8'h15: return 8'h71;
                default: return 8'hFF;
            endcase
        end
        case (mode_i)
            2'd0: return (p[1:0] == 2'b00) ? (s0 | 8'h06) : 8'hFF;
            2'd1: return p[0] ? 8'hFF : ((p[1] ? s1 : s0) | 8'h06);
            default: return (p[1:0] == 2'b00) ? s0 : 8'hFF;
        endcase
    endfunction

    task automatic model_wr(input logic [3:0] p, input logic [7:0] d);
        logic [17:0] r0, r1;
        logic s0, s1;
        int n;
        ev[0] = 0; ev[1] = 0; ea[0] = 0; ea[1] = 0; ed[0] = 0; ed[1] = 0;
        if (mode_i == 2'd1) begin
            if (!p[0]) begin
                if (p[3]) begin m_didx[0] = d; m_didx[1] = d; end
                else m_didx[p[1]] = d;
            end else begin
                s0 = p[3] | !p[1];
                s1 = p[3] | p[1];
                r0 = dual_ref(1'b0, m_didx[0], d);
                r1 = dual_ref(1'b1, m_didx[1], d);
                n = 0;
                if (s0 && r0[17]) begin ev[n] = 1; ea[n] = r0[16:8]; ed[n] = r0[7:0]; n++; end
                if (s1 && r1[17]) begin ev[n] = 1; ea[n] = r1[16:8]; ed[n] = r1[7:0]; end
            end
        end else if (mode_i == 2'd3 && p == 4'hA && d == 8'hFF) m_act = 1;
        else if (mode_i == 2'd3 && p == 4'hA && d == 8'hFE) m_act = 0;
        else if (mode_i == 2'd3 && p == 4'hA && m_act) m_cidx = d;
        else if (mode_i == 2'd3 && p == 4'hB && m_act) begin
            if (m_cidx == 8'h09) m_vl = d;
            if (m_cidx == 8'h0A) m_vr = d;
        end else if (!p[0]) m_idx = (mode_i == 2'd0) ? {1'b0, d} : {p[1], d};
        else begin ev[0] = 1; ea[0] = m_idx; ed[0] = d; end
    endtask

    function automatic string wtag();
        case (mode_i)
            2'd0: return "R2";
            2'd1: return "R5 R6 R7";
            2'd2: return "R3";
            default: return "R9 R10";
        endcase
    endfunction

    task automatic host_wr(input logic [3:0] p, input logic [7:0] d);
        @(negedge clk);
        port_i = p; wdata_i = d; wr_i = 1'b1;
        model_wr(p, d);
        @(negedge clk);
        wr_i = 1'b0;
        for (int i = 0; i < 2; i++) begin
            chk({wtag(), " we"}, reg_we_o, ev[i]);
            if (ev[i]) begin
                chk({wtag(), " addr"}, reg_addr_o, ea[i]);
                chk({wtag(), " data"}, reg_data_o, ed[i]);
            end
            @(negedge clk);
        end
        if (mode_i == 2'd3) begin
            chk("R10 gain left", vol_l_o, m_vl[4:0]);
            chk("R10 gain right", vol_r_o, m_vr[4:0]);
        end
    endtask

    task automatic host_rd(input logic [3:0] p);
        string tg;
        @(negedge clk);
        port_i = p; rd_i = 1'b1;
        stat0_i = 8'($urandom); stat1_i = 8'($urandom);
        #1;
        case (mode_i)
            2'd0: tg = "R2 read";
            2'd1: tg = "R8 read";
            2'd2: tg = "R3 read";
            default: tg = "R11 read";
        endcase
        chk(tg, rdata_o, rd_ref(p, stat0_i, stat1_i));
        @(negedge clk);
        rd_i = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; mode_i = m; wr_i = 0; rd_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_idx = 0; m_didx[0] = 0; m_didx[1] = 0; m_act = 0; m_cidx = 0; m_vl = 8'hFF; m_vr = 8'hFF;
        @(negedge clk);
        chk("R1 R4 we after reset", reg_we_o, (m == 2'd1));
        if (m == 2'd1) begin
            chk("R4 init addr", reg_addr_o, 9'h105);
            chk("R4 init data", reg_data_o, 8'h01);
        end
        chk("R1 gain left", vol_l_o, 5'h1F);
        chk("R1 gain right", vol_r_o, 5'h1F);
        @(negedge clk);
        chk("R1 R4 idle", reg_we_o, 1'b0);
    endtask

    function automatic logic [7:0] pick_data();
        logic [7:0] hot [12] = '{8'h05, 8'hE3, 8'hC4, 8'hC8, 8'hC9, 8'hFF,
                                 8'hFE, 8'h09, 8'h0A, 8'h00, 8'h15, 8'hB0};
        if ($urandom % 2) return hot[$urandom % 12];
        return 8'($urandom);
    endfunction

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            logic [3:0] p;
            p = 4'($urandom);
            if (mode_i == 2'd3 && ($urandom % 5) < 2) p = ($urandom % 2) ? 4'hA : 4'hB;
            if ($urandom % 3 == 0) host_rd(p);
            else host_wr(p, pick_data());
        end
    endtask

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'h5EED);
        // single mode
        do_reset(2'd0);
        host_wr(4'h0, 8'hB3);
        host_wr(4'h1, 8'h21);            // R2 directed
        host_rd(4'h0);
        host_rd(4'h2);
        random_run(200);
        // switch into dual without reset: R4 entry write
        @(negedge clk);
        mode_i = 2'd1;
        @(negedge clk);
        chk("R4 entry we", reg_we_o, 1'b1);
        chk("R4 entry addr", reg_addr_o, 9'h105);
        @(negedge clk);
        chk("R4 entry one shot", reg_we_o, 1'b0);
        random_run(250);
        // extended
        do_reset(2'd2);
        host_wr(4'h2, 8'h05);
        host_wr(4'h3, 8'h03);            // R3: address 0x105
        random_run(200);
        // control chip
        do_reset(2'd3);
        host_wr(4'hA, 8'h09);            // R9: inactive, acts as bank-1 index
        host_wr(4'hB, 8'h44);
        host_wr(4'hA, 8'hFF);            // R9 on
        host_rd(4'hA);                   // R11
        host_wr(4'hA, 8'h09);
        host_wr(4'hB, 8'h13);            // R10 left volume
        host_wr(4'hA, 8'h0A);
        host_wr(4'hB, 8'hE7);            // R10 right volume
        host_rd(4'hB);
        host_wr(4'hA, 8'h15);
        host_rd(4'hB);                   // R11 0x71
        host_wr(4'hA, 8'h33);
        host_wr(4'hB, 8'h55);            // R10 ignored index
        host_rd(4'hB);
        host_wr(4'hA, 8'hFE);            // R9 off
        host_wr(4'hB, 8'h66);            // goes downstream at old index
        random_run(300);
        // dual after reset, directed filters
        do_reset(2'd1);
        host_wr(4'h8, 8'hC2);
        host_wr(4'h9, 8'hFF);            // R7 broadcast pan
        host_wr(4'h8, 8'h05);
        host_wr(4'h9, 8'h00);            // R6 dropped on both
        host_wr(4'h2, 8'hE1);
        host_wr(4'h3, 8'hFF);            // R6 mask, chip 1 only
        host_rd(4'h2);
        host_rd(4'h1);                   // R8
        random_run(250);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule